// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This combinational block prepares the second operand of a data-processing datapath. It takes a 32-bit source word and moves it by a logical left, logical right, arithmetic right or rotate right step. It produces the moved word and the shifter carry-out that a flag-setting operation would record. The shift count comes from one of two places: a 5-bit field carried in the operation word, or the low 8 bits of a register.

A count field of zero has a different meaning for each shift type. For a left shift it means "no shift", and the carry flag passes through untouched. For the two right shifts it stands for a full 32-position shift. For rotate it selects a one-position rotate through the carry flag. Register-supplied counts are taken literally: they saturate instead of wrapping, and the only exception is rotate, which works modulo 32. The flags, the ALU and the decoder that fills these inputs sit outside this block.

Top module: `shifter_operand`

## Requirements
- R1: With the field source selected, kind 00 (logical left) and a field value of 0, `op2_o` equals `src_i` and `carry_o` equals `carry_i`.
- R2: Kind encoding is 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For a count n with 1 ≤ n ≤ 31 the result is the plain shift or rotate. The carry is the last bit moved out: source bit 32−n for left, and bit n−1 for the right shifts and for rotate.
- R3: With the field source selected, kind 01 and field 0 gives a shift by 32: `op2_o` is zero and `carry_o` is `src_i[31]`.
- R4: With the field source selected, kind 10 and field 0 gives a shift by 32: every bit of `op2_o` and `carry_o` equals `src_i[31]`.
- R5: With the field source selected, kind 11 and field 0 rotates the 33-bit value {carry_i, src_i} right by one: `op2_o` is {carry_i, src_i[31:1]} and `carry_o` is `src_i[0]`.
- R6: With the register source selected and a register count of 0, `op2_o` equals `src_i` and `carry_o` equals `carry_i`, for every kind.
- R7: With the register source: a left shift by 32 gives 0 with carry `src_i[0]`; a logical right shift by 32 gives 0 with carry `src_i[31]`; either shift by more than 32 gives 0 with carry 0.
- R8: With the register source, an arithmetic right shift by 32 or more fills `op2_o` with `src_i[31]` and sets `carry_o` to `src_i[31]`.
- R9: With the register source, rotate uses the count modulo 32. A nonzero count that is a multiple of 32 leaves `src_i` unchanged, with carry `src_i[31]`.
- R10: `use_reg_i` = 0 selects `imm_amt_i` and 1 selects `reg_amt_i`. The count that is not selected has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 32 | Source word to be shifted |
| carry_i | input | 1 | Current carry flag |
| kind_i | input | 2 | Shift type (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| use_reg_i | input | 1 | 1 = count from register, 0 = count from field |
| imm_amt_i | input | 5 | Count field from the operation word |
| reg_amt_i | input | 8 | Low byte of the count register |
| op2_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bound checker evaluates on every input change. It covers the zero-field reinterpretations for all four kinds, the register pass-through at count 0, the saturation of register shifts past 32, and the fact that rotate conserves the number of set bits. It also checks that a nonzero left shift always clears bit 0. Exact bit positions and carry values for arbitrary counts 1 to 31, the boundary at exactly 32, rotate modulo 32, and the independence from the unselected count are shown only by the bench. The bench compares every vector against its own behavioural model.

// File: rtl/shifter_operand_pkg.sv
package shifter_operand_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  // How the output stage forms its result
  typedef enum logic [1:0] {
    OM_SHIFT    = 2'b00,  // take barrel result
    OM_PASS     = 2'b01,  // source and incoming carry untouched
    OM_RRX      = 2'b10,  // 33-bit rotate through carry by one
    OM_ROT_FULL = 2'b11   // rotate by nonzero multiple of width
  } out_mode_e;

  // Clamp a raw count to a ceiling
  function automatic int unsigned sat_count(input int unsigned raw,
                                            input int unsigned ceil_v);
    return (raw > ceil_v) ? ceil_v : raw;
  endfunction

endpackage

// File: rtl/shifter_amt_decode.sv
module shifter_amt_decode
  import shifter_operand_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8,
  parameter int CNT_W  = 6
) (
  input  shift_kind_e      kind_i,
  input  logic             use_reg_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [REG_W-1:0] reg_amt_i,
  output out_mode_e        mode_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int LOG_W = $clog2(DATA_W);

  logic [LOG_W-1:0] rot_amt;
  assign rot_amt = reg_amt_i[LOG_W-1:0];

  always_comb begin
    mode_o  = OM_SHIFT;
    count_o = '0;
    if (!use_reg_i) begin
      if (imm_amt_i == '0) begin
        unique case (kind_i)
          SK_LSL:  mode_o  = OM_PASS;
          SK_ROR:  mode_o  = OM_RRX;
          default: count_o = CNT_W'(DATA_W);
        endcase
      end else begin
        count_o = CNT_W'(imm_amt_i);
      end
    end else if (reg_amt_i == '0) begin
      mode_o = OM_PASS;
    end else begin
      unique case (kind_i)
        SK_ROR: begin
          if (rot_amt == '0) mode_o  = OM_ROT_FULL;
          else               count_o = CNT_W'(rot_amt);
        end
        SK_ASR:  count_o = CNT_W'(sat_count(int'(reg_amt_i), DATA_W));
        default: count_o = CNT_W'(sat_count(int'(reg_amt_i), DATA_W + 1));
      endcase
    end
  end

endmodule

// File: rtl/shifter_barrel.sv
module shifter_barrel
  import shifter_operand_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] src_i,
  input  shift_kind_e       kind_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);

  // Window: {upper half, source, guard bit}; the guard catches the carry
  localparam int VEC_W = 2 * DATA_W + 1;

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic              mirror;
  logic              fill_bit;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] upper;
  logic [VEC_W-1:0]  stage [CNT_W+1];
  logic [DATA_W-1:0] body;

  assign mirror   = (kind_i == SK_LSL);
  assign fill_bit = (kind_i == SK_ASR) & src_i[DATA_W-1];
  assign base     = mirror ? bit_rev(src_i) : src_i;
  assign upper    = (kind_i == SK_ROR) ? src_i : {DATA_W{fill_bit}};
  assign stage[0] = {upper, base, 1'b0};

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = count_i[k] ? {{SH{fill_bit}}, stage[k][VEC_W-1:SH]}
                                   : stage[k];
  end

  assign body   = stage[CNT_W][DATA_W:1];
  assign cout_o = stage[CNT_W][0];
  assign res_o  = mirror ? bit_rev(body) : body;

endmodule

// File: rtl/shifter_out_mux.sv
module shifter_out_mux
  import shifter_operand_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  out_mode_e         mode_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] shifted_i,
  input  logic              shift_cout_i,
  output logic [DATA_W-1:0] op2_o,
  output logic              carry_o
);

  always_comb begin
    unique case (mode_i)
      OM_PASS: begin
        op2_o   = src_i;
        carry_o = carry_i;
      end
      OM_RRX: begin
        op2_o   = {carry_i, src_i[DATA_W-1:1]};
        carry_o = src_i[0];
      end
      OM_ROT_FULL: begin
        op2_o   = src_i;
        carry_o = src_i[DATA_W-1];
      end
      default: begin
        op2_o   = shifted_i;
        carry_o = shift_cout_i;
      end
    endcase
  end

endmodule

// File: rtl/shifter_operand.sv
module shifter_operand
  import shifter_operand_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  input  logic [1:0]        kind_i,
  input  logic              use_reg_i,
  input  logic [IMM_W-1:0]  imm_amt_i,
  input  logic [REG_W-1:0]  reg_amt_i,
  output logic [DATA_W-1:0] op2_o,
  output logic              carry_o
);

  // Count must reach DATA_W+1 (saturated "beyond width")
  localparam int CNT_W = $clog2(DATA_W + 2);

  shift_kind_e       kind;
  out_mode_e         mode;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] shifted;
  logic              shift_cout;

  assign kind = shift_kind_e'(kind_i);

  shifter_amt_decode #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_dec (
    .kind_i   (kind),
    .use_reg_i(use_reg_i),
    .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i),
    .mode_o   (mode),
    .count_o  (count)
  );

  shifter_barrel #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_barrel (
    .src_i  (src_i),
    .kind_i (kind),
    .count_i(count),
    .res_o  (shifted),
    .cout_o (shift_cout)
  );

  shifter_out_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .mode_i      (mode),
    .src_i       (src_i),
    .carry_i     (carry_i),
    .shifted_i   (shifted),
    .shift_cout_i(shift_cout),
    .op2_o       (op2_o),
    .carry_o     (carry_o)
  );

endmodule

// File: rtl/shifter_operand_chk.sv
module shifter_operand_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8
) (
  input logic [DATA_W-1:0] src_i,
  input logic              carry_i,
  input logic [1:0]        kind_i,
  input logic              use_reg_i,
  input logic [IMM_W-1:0]  imm_amt_i,
  input logic [REG_W-1:0]  reg_amt_i,
  input logic [DATA_W-1:0] op2_o,
  input logic              carry_o
);

  logic fld_zero, reg_zero, reg_beyond;
  assign fld_zero   = !use_reg_i && (imm_amt_i == '0);
  assign reg_zero   = use_reg_i && (reg_amt_i == '0);
  assign reg_beyond = use_reg_i && (int'(reg_amt_i) > DATA_W);

  always_comb begin
    if (fld_zero && kind_i == 2'b00)
      AST_FLD_LSL_ZERO: assert (op2_o == src_i && carry_o == carry_i); // R1
    if (!use_reg_i && imm_amt_i != '0 && kind_i == 2'b00)
      AST_LSL_LOW_CLEAR: assert (op2_o[0] == 1'b0); // R2
    if (fld_zero && kind_i == 2'b01)
      AST_FLD_LSR_FULL: assert (op2_o == '0 && carry_o == src_i[DATA_W-1]); // R3
    if (fld_zero && kind_i == 2'b10)
      AST_FLD_ASR_FULL: assert (op2_o == {DATA_W{src_i[DATA_W-1]}} && carry_o == src_i[DATA_W-1]); // R4
    if (fld_zero && kind_i == 2'b11)
      AST_FLD_RRX: assert (op2_o[DATA_W-1] == carry_i && op2_o[DATA_W-2:0] == src_i[DATA_W-1:1] && carry_o == src_i[0]); // R5
    if (reg_zero)
      AST_REG_ZERO_PASS: assert (op2_o == src_i && carry_o == carry_i); // R6
    if (reg_beyond && !kind_i[1])
      AST_REG_BEYOND_ZERO: assert (op2_o == '0 && carry_o == 1'b0); // R7
    if (use_reg_i && int'(reg_amt_i) >= DATA_W && kind_i == 2'b10)
      AST_REG_ASR_SAT: assert (op2_o == {DATA_W{src_i[DATA_W-1]}} && carry_o == src_i[DATA_W-1]); // R8
    if (use_reg_i && kind_i == 2'b11)
      AST_ROR_KEEPS_ONES: assert ($countones(op2_o) == $countones(src_i)); // R9
  end

endmodule

bind shifter_operand shifter_operand_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_W(REG_W)
) u_chk (
  .src_i    (src_i),
  .carry_i  (carry_i),
  .kind_i   (kind_i),
  .use_reg_i(use_reg_i),
  .imm_amt_i(imm_amt_i),
  .reg_amt_i(reg_amt_i),
  .op2_o    (op2_o),
  .carry_o  (carry_o)
);

// File: tb/shifter_operand_tb.sv
module shifter_operand_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src;
  logic        cin;
  logic [1:0]  kind;
  logic        use_reg;
  logic [4:0]  imm;
  logic [7:0]  rgc;
  logic [31:0] op2;
  logic        cout;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shifter_operand u_dut (
    .src_i(src), .carry_i(cin), .kind_i(kind), .use_reg_i(use_reg),
    .imm_amt_i(imm), .reg_amt_i(rgc), .op2_o(op2), .carry_o(cout)
  );

  // Behavioural model: returns {carry, result}
  function automatic logic [32:0] model(input logic [31:0] s, input logic c,
                                        input logic [1:0] k, input logic ur,
                                        input logic [4:0] im, input logic [7:0] rg);
    int n;
    int m;
    logic [63:0] t;
    if (!ur) begin
      if (im == 0) begin
        if (k == 2'd0) return {c, s};
        if (k == 2'd3) return {s[0], c, s[31:1]};
        n = 32;
      end else n = int'(im);
    end else begin
      if (rg == 0) return {c, s};
      n = int'(rg);
    end
    case (k)
      2'd0: begin
        if (n > 32) return 33'd0;
        t = {32'd0, s} << n;
        return {t[32], t[31:0]};
      end
      2'd1: begin
        if (n > 32) return 33'd0;
        t = {s, 32'd0} >> n;
        return {t[31], t[63:32]};
      end
      2'd2: begin
        if (n >= 32) return {s[31], {32{s[31]}}};
        return {s[n-1], 32'($signed(s) >>> n)};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {s[31], s};
        return {s[m-1], (s >> m) | (s << (32 - m))};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic ur,
                                   input logic [4:0] im, input logic [7:0] rg);
    if (!ur) begin
      if (im != 0) return "R2";
      case (k)
        2'd0: return "R1";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (rg == 0) return "R6";
    if (k == 2'd3) return (rg % 32 == 0) ? "R9" : "R2";
    if (k == 2'd2) return (rg >= 32) ? "R8" : "R2";
    return (rg >= 32) ? "R7" : "R2";
  endfunction

  task automatic check(input string tag);
    logic [32:0] exp;
    exp = model(src, cin, kind, use_reg, imm, rgc);
    total++;
    if ({cout, op2} !== exp) begin
      bad++;
      $display("FAIL %s: src=%h cin=%0d kind=%0d reg=%0d imm=%0d rg=%0d act=%0d/%h exp=%0d/%h",
               tag, src, cin, kind, use_reg, imm, rgc, cout, op2, exp[32], exp[31:0]);
    end
  endtask

  // Drive one vector after a rising edge, compare at the falling edge
  task automatic apply(input logic [31:0] s, input logic c, input logic [1:0] k,
                       input logic ur, input logic [4:0] im, input logic [7:0] rg,
                       input string tag);
    @(posedge clk);
    #1;
    src = s; cin = c; kind = k; use_reg = ur; imm = im; rgc = rg;
    @(negedge clk);
    check(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    src = '0; cin = 1'b0; kind = 2'd0; use_reg = 1'b0; imm = '0; rgc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");  // reset state: zero source passes through
    rst_n = 1'b1;

    // R1 field LSL 0
    apply(32'hDEAD_BEEF, 1'b1, 2'd0, 1'b0, 5'd0, 8'd7, "R1");
    apply(32'h1234_5678, 1'b0, 2'd0, 1'b0, 5'd0, 8'd0, "R1");
    // R2 ordinary counts, edges 1 and 31
    apply(32'h8000_0001, 1'b0, 2'd0, 1'b0, 5'd1,  8'd0, "R2");
    apply(32'h0000_0003, 1'b0, 2'd0, 1'b0, 5'd31, 8'd0, "R2");
    apply(32'h8000_0001, 1'b0, 2'd1, 1'b0, 5'd1,  8'd0, "R2");
    apply(32'h8000_0000, 1'b0, 2'd2, 1'b0, 5'd31, 8'd0, "R2");
    apply(32'h0000_0001, 1'b0, 2'd3, 1'b0, 5'd1,  8'd0, "R2");
    // R3 / R4 / R5 field zero
    apply(32'h8000_0000, 1'b0, 2'd1, 1'b0, 5'd0, 8'd0, "R3");
    apply(32'h7FFF_FFFF, 1'b1, 2'd1, 1'b0, 5'd0, 8'd0, "R3");
    apply(32'h8000_0000, 1'b0, 2'd2, 1'b0, 5'd0, 8'd0, "R4");
    apply(32'h7FFF_FFFF, 1'b1, 2'd2, 1'b0, 5'd0, 8'd0, "R4");
    apply(32'h0000_0001, 1'b1, 2'd3, 1'b0, 5'd0, 8'd0, "R5");
    apply(32'hFFFF_FFFE, 1'b0, 2'd3, 1'b0, 5'd0, 8'd0, "R5");
    // R6 register zero, every kind
    for (int k = 0; k < 4; k++)
      apply(32'hA5A5_0F0F, 1'b1, 2'(k), 1'b1, 5'd0, 8'd0, "R6");
    // R7 boundaries around 32
    apply(32'h0000_0001, 1'b0, 2'd0, 1'b1, 5'd0, 8'd32,  "R7");
    apply(32'hFFFF_FFFF, 1'b1, 2'd0, 1'b1, 5'd0, 8'd33,  "R7");
    apply(32'h8000_0000, 1'b0, 2'd1, 1'b1, 5'd0, 8'd32,  "R7");
    apply(32'hFFFF_FFFF, 1'b1, 2'd1, 1'b1, 5'd0, 8'd255, "R7");
    // R8 arithmetic saturation
    apply(32'h8000_0000, 1'b0, 2'd2, 1'b1, 5'd0, 8'd32,  "R8");
    apply(32'h4000_0000, 1'b1, 2'd2, 1'b1, 5'd0, 8'd200, "R8");
    // R9 rotate modulo width
    apply(32'h8000_0001, 1'b0, 2'd3, 1'b1, 5'd0, 8'd32,  "R9");
    apply(32'h0000_0001, 1'b1, 2'd3, 1'b1, 5'd0, 8'd64,  "R9");
    apply(32'h0000_00F0, 1'b0, 2'd3, 1'b1, 5'd0, 8'd36,  "R9");
    // R10 unselected count has no effect
    apply(32'h0F0F_1234, 1'b0, 2'd1, 1'b0, 5'd4, 8'd255, "R10");
    apply(32'h0F0F_1234, 1'b0, 2'd1, 1'b0, 5'd4, 8'd1,   "R10");
    apply(32'h0F0F_1234, 1'b1, 2'd0, 1'b1, 5'd0, 8'd40,  "R10");
    apply(32'h0F0F_1234, 1'b1, 2'd3, 1'b1, 5'd31, 8'd0,  "R10");

    // Random sweep compared every clock
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s;
      logic [1:0]  k;
      logic        ur;
      logic [4:0]  im;
      logic [7:0]  rg;
      s  = $urandom;
      k  = 2'($urandom);
      ur = 1'($urandom);
      im = 5'($urandom);
      rg = (i % 4 == 0) ? 8'(32 * ($urandom % 8)) : 8'($urandom);
      apply(s, 1'($urandom), k, ur, im, rg, tag_of(k, ur, im, rg));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule